// File: doc/BRIEF.md
# DMA Channel Interrupt Register Bank

This block sits beside one channel of a memory-to-peripheral DMA engine and turns the engine's completion signals into software-visible status and a single interrupt line. The engine delivers a one-cycle pulse when a transfer finishes and a one-cycle pulse when an abort has been carried out. The block shows these events four ways:

- a live view of the event inputs in the current cycle;
- a sticky copy that software clears by writing ones;
- an enable mask;
- a detect view, which is the sticky copy masked by the enables.

The channel interrupt is driven from the detect view through a flop.

Software reaches the four words through a simple 32-bit register port with a combinational read path. A driver programs the enables, starts a transfer elsewhere and then either waits for the interrupt or polls the sticky word. An abort is latched on the clock edge that samples its pulse, so a polling loop sees it at once. An abort also reports the done event, so a handler that only looks at the done bit still sees that the channel has gone idle.

Top module: `dmach_irq_regs`

## Requirements
- R1: After reset the sticky, enable and detect words read 0 and `irq_o` is low.
- R2: Offset 0x10 reads the event inputs of the current cycle, with bit 1 = done OR abort and bit 13 = abort, and all other bits 0. A write to 0x10 changes no register.
- R3: An abort pulse sets both bit 13 and bit 1 of the sticky word (offset 0x14) on the clock edge that samples it.
- R4: A sticky bit stays set until a write to 0x14 has a 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R5: If an event and a write-1-to-clear of the same bit fall in the same cycle, the bit remains set.
- R6: Offset 0x18 holds the enable mask. Only bits 1 and 13 are stored, and all other bits read 0.
- R7: Offset 0x1C reads the sticky word AND the enable word. A write to 0x1C changes no register.
- R8: `irq_o` equals the OR of the detect bits as they stood one cycle earlier.
- R9: Any other offset reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the accessed word |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_done_pulse | input | 1 | Transfer-finished pulse from the engine |
| eng_abort_pulse | input | 1 | Abort-carried-out pulse from the engine |
| irq_o | output | 1 | Registered channel interrupt |

## Verification
On every cycle, the assertions check these properties:

- an abort sets both sticky bits;
- an event beats a simultaneous clear;
- a sticky bit survives any write that does not carry a 1 in its position;
- a clear without an event empties the bit;
- the interrupt tracks the detect OR one cycle late.

The bench's scenarios cover the rest. It sweeps every enable pattern against each event kind and compares the read words and the interrupt timing with values it works out itself. Separate scenarios show that the live view follows the inputs, that only the two stored enable bits survive, and that writes to the read-only and unmapped offsets leave the other registers untouched.

// File: rtl/dmach_irq_pkg.sv
package dmach_irq_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned BIT_DONE  = 1;
  localparam int unsigned BIT_ABORT = 13;
  localparam logic [REG_W-1:0] EVT_MASK =
    (REG_W'(1) << BIT_DONE) | (REG_W'(1) << BIT_ABORT);

  localparam logic [7:0] OFS_LIVE   = 8'h10;
  localparam logic [7:0] OFS_STICKY = 8'h14;
  localparam logic [7:0] OFS_ENABLE = 8'h18;
  localparam logic [7:0] OFS_DETECT = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LIVE, SEL_STICKY, SEL_ENABLE, SEL_DETECT
  } reg_sel_e;

  // Abort also reports done.
  function automatic logic [REG_W-1:0] event_word(input logic done,
                                                  input logic abort);
    logic [REG_W-1:0] w;
    w = '0;
    w[BIT_DONE]  = done | abort;
    w[BIT_ABORT] = abort;
    return w;
  endfunction

  // Set has priority over clear.
  function automatic logic sticky_next(input logic q, input logic set,
                                       input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch
  import dmach_irq_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter logic [W-1:0] MASK = EVT_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o[b] <= 1'b0;
        else        q_o[b] <= sticky_next(q_o[b], set_i[b], clr_i[b]);
      end
    end else begin : g_tie
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import dmach_irq_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter logic [W-1:0] MASK = EVT_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import dmach_irq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] sticky_i,
  input  logic [W-1:0] enable_i,
  input  logic [W-1:0] detect_i,
  output logic [W-1:0] rdata_o
);
  always_comb begin
    unique case (sel_i)
      SEL_LIVE:   rdata_o = live_i;
      SEL_STICKY: rdata_o = sticky_i;
      SEL_ENABLE: rdata_o = enable_i;
      SEL_DETECT: rdata_o = detect_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dmach_irq_regs.sv
module dmach_irq_regs
  import dmach_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              eng_done_pulse,
  input  logic              eng_abort_pulse,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic [REG_W-1:0] live_word;
  logic [REG_W-1:0] sticky_word;
  logic [REG_W-1:0] enable_word;
  logic [REG_W-1:0] detect_word;
  logic [REG_W-1:0] clr_word;
  logic             wr_sticky;
  logic             wr_enable;
  logic             detect_any;
  logic             irq_q;

  always_comb begin
    if      (reg_addr == ADDR_W'(OFS_LIVE))   sel = SEL_LIVE;
    else if (reg_addr == ADDR_W'(OFS_STICKY)) sel = SEL_STICKY;
    else if (reg_addr == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
    else if (reg_addr == ADDR_W'(OFS_DETECT)) sel = SEL_DETECT;
    else                                      sel = SEL_NONE;
  end

  assign wr_sticky   = reg_wr && (sel == SEL_STICKY);
  assign wr_enable   = reg_wr && (sel == SEL_ENABLE);
  assign live_word   = event_word(eng_done_pulse, eng_abort_pulse);
  assign clr_word    = wr_sticky ? (reg_wdata & EVT_MASK) : '0;
  assign detect_word = sticky_word & enable_word;
  assign detect_any  = |detect_word;

  irq_event_latch #(.W(REG_W), .MASK(EVT_MASK)) i_latch (
    .clk(clk), .rst_n(rst_n),
    .set_i(live_word), .clr_i(clr_word), .q_o(sticky_word)
  );

  irq_enable_reg #(.W(REG_W), .MASK(EVT_MASK)) i_enable (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_enable), .wdata_i(reg_wdata), .q_o(enable_word)
  );

  irq_read_mux #(.W(REG_W)) i_rmux (
    .sel_i(sel), .live_i(live_word), .sticky_i(sticky_word),
    .enable_i(enable_word), .detect_i(detect_word), .rdata_o(reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= detect_any;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/dmach_irq_chk.sv
module dmach_irq_chk
  import dmach_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             done_i,
  input logic             abort_i,
  input logic             wr_sticky,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] sticky,
  input logic [REG_W-1:0] detect,
  input logic             irq
);
  AST_ABORT_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (sticky[BIT_DONE] && sticky[BIT_ABORT])); // R3

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && wr_sticky && wdata[BIT_DONE]) |=> sticky[BIT_DONE]); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky[BIT_DONE] && !(wr_sticky && wdata[BIT_DONE])) |=> sticky[BIT_DONE]); // R4

  AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky[BIT_ABORT] && !(wr_sticky && wdata[BIT_ABORT])) |=> sticky[BIT_ABORT]); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sticky && wdata[BIT_DONE] && !done_i && !abort_i) |=> !sticky[BIT_DONE]); // R4

  AST_IRQ_LAGS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|detect))); // R8
endmodule

bind dmach_irq_regs dmach_irq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .done_i(eng_done_pulse), .abort_i(eng_abort_pulse),
  .wr_sticky(wr_sticky), .wdata(reg_wdata), .sticky(sticky_word),
  .detect(detect_word), .irq(irq_o)
);

// File: tb/test_dmach_irq_regs.sv
`timescale 1ns/1ps
module test_dmach_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        done_p = 1'b0;
  logic        abort_p = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_sticky = '0;
  logic [31:0] exp_en = '0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  dmach_irq_regs i_dmach_irq_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_done_pulse(done_p), .eng_abort_pulse(abort_p), .irq_o(irq)
  );

  // Expected event word: bit 1 = done|abort, bit 13 = abort.
  function automatic logic [31:0] ev(input logic d, input logic a);
    return ({31'd0, a} << 13) | ({31'd0, d || a} << 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.4;
    v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 8'h14) exp_sticky = exp_sticky & ~d;
    if (a == 8'h18) exp_en = d & 32'h0000_2002;
  endtask

  task automatic pulse(input logic d, input logic a);
    @(negedge clk);
    done_p = d; abort_p = a;
    @(negedge clk);
    done_p = 1'b0; abort_p = 1'b0;
    exp_sticky = exp_sticky | ev(d, a);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_reg(8'h14, rd); check("R1 sticky", rd, 32'h0);
    rd_reg(8'h18, rd); check("R1 enable", rd, 32'h0);
    rd_reg(8'h1C, rd); check("R1 detect", rd, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);

    // R2 live view follows inputs in the same cycle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      done_p = k[0]; abort_p = k[1];
      rd_reg(8'h10, rd); check("R2 live", rd, ev(k[0], k[1]));
      @(negedge clk);
      done_p = 1'b0; abort_p = 1'b0;
      exp_sticky = exp_sticky | ev(k[0], k[1]);
    end
    wr_reg(8'h14, 32'hFFFF_FFFF);

    // Sweep enable pattern x event kind: R3 R6 R7 R8
    for (int en = 0; en < 4; en++) begin
      for (int kind = 0; kind < 3; kind++) begin
        logic [31:0] m;
        logic [31:0] det;
        wr_reg(8'h14, 32'hFFFF_FFFF);
        m = ({31'd0, en[1]} << 13) | ({31'd0, en[0]} << 1);
        wr_reg(8'h18, m | 32'h8000_0001);
        pulse(kind == 1, kind == 2);
        det = exp_sticky & exp_en;
        check("R8 irq lag", {31'd0, irq}, 32'h0);
        rd_reg(8'h14, rd); check(kind == 2 ? "R3 abort sets both" : "R4 sticky", rd, exp_sticky);
        rd_reg(8'h18, rd); check("R6 enable", rd, exp_en);
        rd_reg(8'h1C, rd); check("R7 detect", rd, det);
        @(negedge clk);
        check("R8 irq", {31'd0, irq}, {31'd0, |det});
      end
    end

    // R4 write zero keeps, write one clears only its bit
    wr_reg(8'h18, 32'h0);
    pulse(1'b0, 1'b1);
    wr_reg(8'h14, 32'h0);
    rd_reg(8'h14, rd); check("R4 zero write", rd, 32'h0000_2002);
    wr_reg(8'h14, 32'h0000_2000);
    rd_reg(8'h14, rd); check("R4 partial clear", rd, 32'h0000_0002);

    // R5 event and clear in the same cycle
    wr_reg(8'h14, 32'hFFFF_FFFF);
    pulse(1'b1, 1'b0);
    @(negedge clk);
    reg_addr = 8'h14; reg_wdata = 32'h0000_0002; reg_wr = 1'b1; done_p = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; done_p = 1'b0;
    rd_reg(8'h14, rd); check("R5 event wins", rd, 32'h0000_0002);

    // R2 R7 R9 writes to read-only and unmapped offsets
    wr_reg(8'h18, 32'h0000_0002);
    exp_sticky = 32'h0000_0002;
    wr_reg(8'h10, 32'hFFFF_FFFF);
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    wr_reg(8'h20, 32'hFFFF_FFFF);
    wr_reg(8'h04, 32'hFFFF_FFFF);
    rd_reg(8'h14, rd); check("R7 R2 R9 sticky untouched", rd, 32'h0000_0002);
    rd_reg(8'h18, rd); check("R9 enable untouched", rd, 32'h0000_0002);
    rd_reg(8'h1C, rd); check("R7 detect", rd, 32'h0000_0002);
    rd_reg(8'h00, rd); check("R9 read zero", rd, 32'h0);
    rd_reg(8'h20, rd); check("R9 read zero", rd, 32'h0);
    check("R8 irq steady", {31'd0, irq}, 32'h1);

    // R8 clearing drops irq one cycle later
    wr_reg(8'h14, 32'h0000_0002);
    check("R8 irq lag on clear", {31'd0, irq}, 32'h1);
    @(negedge clk);
    check("R8 irq cleared", {31'd0, irq}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule